// File: doc/BRIEF.md
# Step-Start Turn-On Pulse Generator

This block is a retriggerable digital monostable. It produces the turn-on pulse that holds the first-stage contactor closed during a transmitter's step-start sequence. It has a true output and a complementary output. At rest the true output is low. A trigger drives it high for a fixed time, nominally 1.6 s. That time is counted on the system clock, so the frequency and the width are parameters.

The block has two trigger sources:
- a rising edge on the turn-on request;
- the release (rising edge) of the active-low clear, but only when the select input is low and the request is high.

The inhibit input refuses new triggers but lets a pulse that is already running finish. The clear input ends a pulse in the same cycle it falls, and holds the block idle for as long as it stays low. The fault logic that drives clear, and the contactors, sit outside this block.

Top module: `step_start_oneshot`

## Requirements
- R1: While reset is asserted and after it is released, with no trigger, `pulse_q` is 0 and `pulse_qn` is 1.
- R2: `pulse_qn` is always the inverse of `pulse_q`.
- R3: A 0-to-1 change on `turn_on_req`, seen at a clock edge while `clear_n` is 1 and `inhibit` is 0, sets `pulse_q` to 1 after that edge. `pulse_q` then stays 1 for exactly `PULSE_CYCLES` clock cycles, where `PULSE_CYCLES` = `CLK_HZ` * `PULSE_US` / 1,000,000.
- R4: A 0-to-1 change on `clear_n` triggers a pulse as in R3 when `clr_trig_sel_n` is 0, `turn_on_req` is 1 and `inhibit` is 0. When `clr_trig_sel_n` is 1, the release of clear does not trigger.
- R5: A trigger edge that arrives while `inhibit` is 1 is discarded. It does not start a pulse at that time, and it does not start one later when `inhibit` falls.
- R6: Raising `inhibit` while a pulse runs does not shorten that pulse.
- R7: `clear_n` at 0 forces `pulse_q` to 0 in the same cycle, without waiting for a clock edge, and the running pulse is ended.
- R8: While `clear_n` is 0, request edges are discarded. None of them starts a pulse after clear is released.
- R9: A valid trigger during a running pulse restarts the full width, so `pulse_q` stays 1 for `PULSE_CYCLES` cycles counted from the retrigger edge.
- R10: A level on `turn_on_req` that is held high triggers at most once. A request that is already high when reset is released is not treated as an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| turn_on_req | input | 1 | Turn-on request; its rising edge is a trigger |
| clr_trig_sel_n | input | 1 | When low, the release of clear may trigger |
| inhibit | input | 1 | Blocks new triggers; a running pulse completes |
| clear_n | input | 1 | Active-low clear; aborts the pulse at once |
| pulse_q | output | 1 | True pulse output, high while the pulse runs |
| pulse_qn | output | 1 | Complementary pulse output |

## Verification
The assertions assume that all four control inputs are synchronous to `clk` and stable around its rising edge. They assume that an edge means a change between two sampled clock edges, so they say nothing about the first cycle after reset. They also take `clear_n` to be the only way a pulse may end before `PULSE_CYCLES` high cycles. The bench keeps to these assumptions. It changes every input on the falling clock edge. It shortens the pulse width through the parameters, so that each scenario can wait out a whole pulse. It also holds reset for several cycles before the first stimulus.

// File: rtl/sso_pkg.sv
// Shared definitions for the step-start turn-on pulse generator.
// Assumes: cycle arithmetic fits in 64 bits.
package sso_pkg;

    // Rising edges detected on the registered inputs.
    typedef struct packed {
        logic req_rise;
        logic clr_rise;
    } sso_edges_t;

    // Pulse width in clock cycles for a clock rate and a width in microseconds.
    function automatic int unsigned calc_cycles(input longint unsigned clk_hz,
                                                input longint unsigned width_us);
        longint unsigned prod;
        prod = (clk_hz * width_us) / 64'd1_000_000;
        return (prod == 0) ? 1 : int'(prod);
    endfunction

endpackage

// File: rtl/sso_edge_det.sv
// Registered rising-edge detector for N synchronous inputs.
// Assumes: inputs are synchronous to clk. The delayed copies reset to
// RST_VAL, so a level already present at reset release is not an edge
// when RST_VAL is 1.
module sso_edge_det #(
    parameter int unsigned N       = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);

    logic [N-1:0] din_d;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Keep one-cycle-old copy of each input.
        always_ff @(posedge clk) begin
            if (!rst_n) din_d[i] <= RST_VAL;
            else        din_d[i] <= din[i];
        end

        // Flag a low-to-high change between two sampled edges.
        always_comb rise[i] = din[i] & ~din_d[i];
    end

endmodule

// File: rtl/sso_trigger_qual.sv
// Decides whether the current cycle carries a valid trigger.
// Assumes: edges come from sso_edge_det on the same clock.
module sso_trigger_qual
    import sso_pkg::*;
(
    input  sso_edges_t edges,
    input  logic       req_lvl,
    input  logic       clr_trig_sel_n,
    input  logic       inhibit,
    input  logic       clear_n,
    output logic       fire
);

    logic clr_path;

    // Release of clear qualifies only with select low and request high.
    always_comb clr_path = edges.clr_rise & ~clr_trig_sel_n & req_lvl;

    // Any trigger is refused while inhibited or while clear is held.
    always_comb fire = clear_n & ~inhibit & (edges.req_rise | clr_path);

endmodule

// File: rtl/sso_pulse_timer.sv
// Down-counter that holds the pulse for CYCLES clock cycles.
// Assumes: abort has priority over fire; a fire while running reloads.
module sso_pulse_timer #(
    parameter int unsigned CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic abort,
    output logic active
);

    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] remain;

    // Load on trigger, count down while running, clear on abort.
    always_ff @(posedge clk) begin
        if (!rst_n)             remain <= '0;
        else if (abort)         remain <= '0;
        else if (fire)          remain <= LOAD;
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    // Pulse is active while cycles remain.
    always_comb active = (remain != '0);

endmodule

// File: rtl/step_start_oneshot.sv
// Retriggerable monostable for the step-start turn-on pulse.
// Assumes: all inputs are synchronous to clk. clear_n gates the outputs
// combinationally, so the pulse drops in the same cycle clear falls.
module step_start_oneshot
    import sso_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 1_000_000,
    parameter int unsigned PULSE_US = 1_600_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic turn_on_req,
    input  logic clr_trig_sel_n,
    input  logic inhibit,
    input  logic clear_n,
    output logic pulse_q,
    output logic pulse_qn
);

    localparam int unsigned PULSE_CYCLES = calc_cycles(64'(CLK_HZ), 64'(PULSE_US));

    logic [1:0] rise_vec;
    sso_edges_t edges;
    logic       fire;
    logic       active;

    sso_edge_det #(.N(2), .RST_VAL(1'b1)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({turn_on_req, clear_n}),
        .rise  (rise_vec)
    );

    // Map the detector bits onto named edges.
    always_comb begin
        edges.req_rise = rise_vec[1];
        edges.clr_rise = rise_vec[0];
    end

    sso_trigger_qual u_qual (
        .edges          (edges),
        .req_lvl        (turn_on_req),
        .clr_trig_sel_n (clr_trig_sel_n),
        .inhibit        (inhibit),
        .clear_n        (clear_n),
        .fire           (fire)
    );

    sso_pulse_timer #(.CYCLES(PULSE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .abort  (~clear_n),
        .active (active)
    );

    // Outputs: running pulse, masked immediately by clear.
    always_comb begin
        pulse_q  = active & clear_n;
        pulse_qn = ~pulse_q;
    end

endmodule

// File: rtl/sso_chk.sv
// Property checker for step_start_oneshot, attached by bind.
// Assumes: synchronous inputs. Edge properties wait one cycle after
// reset so that $past never refers to reset-time values.
module sso_chk #(
    parameter int unsigned CLK_HZ   = 1_000_000,
    parameter int unsigned PULSE_US = 1_600_000
) (
    input logic clk,
    input logic rst_n,
    input logic turn_on_req,
    input logic clr_trig_sel_n,
    input logic inhibit,
    input logic clear_n,
    input logic pulse_q
);

    localparam int unsigned W  = sso_pkg::calc_cycles(64'(CLK_HZ), 64'(PULSE_US));
    localparam int unsigned HW = $clog2(W + 2);

    logic          settled;
    logic [HW-1:0] hi_run;

    // Mark when a full post-reset cycle has been sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) settled <= 1'b0;
        else        settled <= 1'b1;
    end

    // Count consecutive high cycles of the pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                    hi_run <= '0;
        else if (!pulse_q)             hi_run <= '0;
        else if (hi_run != HW'(W + 1)) hi_run <= hi_run + 1'b1;
    end

    // R7
    clear_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |-> !pulse_q);

    // R3
    req_edge_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $rose(turn_on_req) && clear_n && !inhibit) |=> pulse_q);

    // R4
    clr_edge_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $rose(clear_n) && !clr_trig_sel_n && turn_on_req && !inhibit) |=> pulse_q);

    // R4
    clr_edge_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $rose(clear_n) && clr_trig_sel_n && !$rose(turn_on_req)) |=> !pulse_q);

    // R5
    inhibit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !pulse_q) |=> !pulse_q);

    // R6
    full_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $fell(pulse_q) && clear_n) |-> (hi_run >= HW'(W)));

endmodule

bind step_start_oneshot sso_chk #(.CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .turn_on_req    (turn_on_req),
    .clr_trig_sel_n (clr_trig_sel_n),
    .inhibit        (inhibit),
    .clear_n        (clear_n),
    .pulse_q        (pulse_q)
);

// File: tb/step_start_oneshot_bench.sv
// Directed bench: one task per scenario, inputs driven and outputs
// sampled on the falling edge.
module step_start_oneshot_bench;

    localparam int unsigned CLK_HZ   = 20;
    localparam int unsigned PULSE_US = 1_600_000;
    localparam int unsigned W        = 32;   // 20 * 1.6

    logic clk = 1'b0;
    logic rst_n, req, sel_n, inh, clr_n;
    logic q, qn;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always #2.5 clk = ~clk;

    step_start_oneshot #(.CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US)) u_step_start_oneshot (
        .clk            (clk),
        .rst_n          (rst_n),
        .turn_on_req    (req),
        .clr_trig_sel_n (sel_n),
        .inhibit        (inh),
        .clear_n        (clr_n),
        .pulse_q        (q),
        .pulse_qn       (qn)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // R1 and R10: idle after reset, even with request held high.
    task automatic t_reset();
        rst_n = 0; req = 1; sel_n = 1; inh = 0; clr_n = 1;
        step(4);
        chk("R1 q in reset", q, 1'b0);
        chk("R1 qn in reset", qn, 1'b1);
        rst_n = 1;
        step(3);
        chk("R10 held request at reset release", q, 1'b0);
        chk("R2 qn idle", qn, 1'b1);
        req = 0;
        step(2);
    endtask

    // R3, R2, R10: basic pulse of exact width, held level fires once.
    task automatic t_basic();
        req = 1;
        step(1);
        chk("R3 q high after edge", q, 1'b1);
        chk("R2 qn low in pulse", qn, 1'b0);
        step(W - 1);
        chk("R3 q high at last cycle", q, 1'b1);
        step(1);
        chk("R3 q low after width", q, 1'b0);
        step(5);
        chk("R10 no retrigger on held level", q, 1'b0);
        req = 0;
        step(2);
    endtask

    // R5: edge during inhibit discarded, not remembered.
    task automatic t_inhibit_block();
        inh = 1;
        step(1);
        req = 1;
        step(3);
        chk("R5 inhibited edge ignored", q, 1'b0);
        inh = 0;
        step(3);
        chk("R5 edge not remembered", q, 1'b0);
        req = 0;
        step(2);
    endtask

    // R6: inhibit raised mid-pulse lets it complete.
    task automatic t_inhibit_mid();
        req = 1;
        step(5);
        inh = 1;
        step(W - 5);
        chk("R6 pulse completes under inhibit", q, 1'b1);
        step(1);
        chk("R6 pulse ends on time", q, 1'b0);
        inh = 0; req = 0;
        step(2);
    endtask

    // R7, R8, R4: clear aborts at once, blocks edges, masked release.
    task automatic t_clear();
        req = 1;
        step(5);
        chk("R7 pulse running before clear", q, 1'b1);
        clr_n = 0;
        #1;
        chk("R7 clear drops q same cycle", q, 1'b0);
        chk("R2 qn high on clear", qn, 1'b1);
        step(1);
        req = 0;
        step(1);
        req = 1;
        step(3);
        chk("R8 edge during clear ignored", q, 1'b0);
        sel_n = 1;
        clr_n = 1;
        step(3);
        chk("R4 masked clear release", q, 1'b0);
        chk("R8 edge not remembered", q, 1'b0);
        req = 0;
        step(2);
    endtask

    // R4: release of clear triggers with select low and request high.
    task automatic t_clr_trigger();
        req = 1;
        clr_n = 0;
        step(2);
        sel_n = 0;
        clr_n = 1;
        step(1);
        chk("R4 clear release triggers", q, 1'b1);
        step(W - 1);
        chk("R4 full width last cycle", q, 1'b1);
        step(1);
        chk("R4 pulse ends", q, 1'b0);
        sel_n = 1; req = 0;
        step(2);
    endtask

    // R9: retrigger restarts the full width.
    task automatic t_retrigger();
        req = 1;
        step(10);
        req = 0;
        step(2);
        req = 1;
        step(W);
        chk("R9 still high past first width", q, 1'b1);
        step(1);
        chk("R9 low after restarted width", q, 1'b0);
        req = 0;
        step(2);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_inhibit_block();
        t_inhibit_mid();
        t_clear();
        t_clr_trigger();
        t_retrigger();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule